// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast oscillator-side clock down to a comparison pulse for a phase detector. It models a dual-modulus prescaler in synchronous logic, dividing by P or P+1, and places two down-counters behind it. The swallow counter keeps the prescaler at P+1 for the first A prescaler outputs of each output period. The main counter closes the period after N prescaler outputs in all. The resulting division ratio is P·N + A, where P is 32 or 64.

New ratios are written through a parallel load strobe and checked first. A legal set waits in a pending register and is applied only when the current output period ends, so every period is whole. An illegal set is refused, the previously accepted values stay in force, and an error flag is raised.

Top module: `pulse_swallow_div`

## Requirements
- R1: After reset, `fp_pulse` and `ratio_err` are 0 and the divider runs at the reset-default ratio (N=8, A=3, narrow prescaler). `mod_ctrl` is 1 because A is not zero.
- R2: With `narrow_sel`=1 (prescaler 32/33), the spacing between consecutive `fp_pulse` pulses is 32·N+A input cycles.
- R3: With `narrow_sel`=0 (prescaler 64/65), the spacing between consecutive `fp_pulse` pulses is 64·N+A input cycles.
- R4: In each output period, `mod_ctrl` (1 = divide by P+1) is high for exactly A·(P+1) input cycles. These cycles come first, starting in the cycle in which `fp_pulse` is high, and `mod_ctrl` then stays low for the rest of the period.
- R5: When A is 0, `mod_ctrl` stays low for the whole period and the spacing is P·N.
- R6: `fp_pulse` is high for exactly one input cycle per period.
- R7: A legal set loaded in the middle of a period does not change the length of that period. It governs every period from the next one on.
- R8: A load with N below 5 sets `ratio_err` in the cycle after the strobe and leaves the ratio in use unchanged.
- R9: A load with A not less than N (A equal to N included) sets `ratio_err` and leaves the ratio in use unchanged.
- R10: A later legal load clears `ratio_err` in the cycle after its strobe.
- R11: The limit setting N=5 with A=N-1=4 is accepted and divides by 32·5+4=164 with the narrow prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-side input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_n | input | 11 | Main count N to load |
| ratio_a | input | 7 | Swallow count A to load |
| narrow_sel | input | 1 | Prescaler select to load: 1 = 32/33, 0 = 64/65 |
| ratio_load | input | 1 | One-cycle strobe that offers ratio_n, ratio_a and narrow_sel |
| fp_pulse | output | 1 | One-cycle divided comparison pulse |
| mod_ctrl | output | 1 | Modulus control: 1 = prescaler divides by P+1 |
| ratio_err | output | 1 | Last load was refused as illegal |

## Verification
A wrong count left in the swallow or main counter shows up as wrong pulse spacing within a single output period. It also shows up as a `mod_ctrl` high time that is not A·(P+1). A wrong prescaler phase or modulus changes the spacing by at least one cycle in the same period. A pending set applied at the wrong moment shows up as a period of mixed length, seen at the first `fp_pulse` after the load. A wrong legality decision is visible on `ratio_err` one cycle after the strobe, and in the spacing of the next period.

// File: rtl/psw_pkg.sv
package psw_pkg;
   localparam int unsigned N_MIN = 5;

   typedef enum logic {
      PSC_WIDE   = 1'b0,
      PSC_NARROW = 1'b1
   } psc_mode_e;

   function automatic logic ratio_ok(input int unsigned n, input int unsigned a);
      return (n >= N_MIN) && (a < n);
   endfunction
endpackage

// File: rtl/psw_cfg.sv
module psw_cfg
   import psw_pkg::*;
#(
   parameter int NW      = 11,
   parameter int AW      = 7,
   parameter int DEF_N   = 8,
   parameter int DEF_A   = 3,
   parameter bit DEF_SEL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [NW-1:0] ld_n,
   input  logic [AW-1:0] ld_a,
   input  logic          ld_sel,
   input  logic          bnd,
   output logic [NW-1:0] nxt_n,
   output logic [AW-1:0] nxt_a,
   output psc_mode_e     act_mode,
   output logic          err
);
   logic      ok;
   psc_mode_e pend_mode;

   assign ok = ratio_ok(32'(ld_n), 32'(ld_a));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nxt_n     <= NW'(DEF_N);
         nxt_a     <= AW'(DEF_A);
         pend_mode <= psc_mode_e'(DEF_SEL);
         act_mode  <= psc_mode_e'(DEF_SEL);
         err       <= 1'b0;
      end else begin
         if (ld) begin
            if (ok) begin
               nxt_n     <= ld_n;
               nxt_a     <= ld_a;
               pend_mode <= psc_mode_e'(ld_sel);
               err       <= 1'b0;
            end else begin
               err <= 1'b1;
            end
         end
         if (bnd) act_mode <= pend_mode;
      end
   end

   assert_keep_on_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !ok) |=> ($stable(nxt_n) && $stable(nxt_a) && err));
   assert_pend_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_n >= NW'(N_MIN)) && (32'(nxt_a) < 32'(nxt_n)));
   assert_mode_at_bnd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> $stable(act_mode));
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler
   import psw_pkg::*;
#(
   parameter int P_LO = 32,
   parameter int P_HI = 64
) (
   input  logic      clk,
   input  logic      rst_n,
   input  psc_mode_e mode,
   input  logic      mod_hi,
   output logic      tick
);
   localparam int CW = $clog2(P_HI + 1);
   localparam logic [CW-1:0] LAST_LO = CW'(P_LO - 1);
   localparam logic [CW-1:0] LAST_HI = CW'(P_HI - 1);

   generate
      if (P_LO < 2 || P_HI <= P_LO) begin : g_bad_modulus
         $error("psw_prescaler: moduli must satisfy 2 <= P_LO < P_HI");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   assign last = ((mode == PSC_NARROW) ? LAST_LO : LAST_HI) + CW'(mod_hi);
   assign tick = (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= last);
endmodule

// File: rtl/psw_counters.sv
module psw_counters #(
   parameter int NW    = 11,
   parameter int AW    = 7,
   parameter int DEF_N = 8,
   parameter int DEF_A = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [NW-1:0] nxt_n,
   input  logic [AW-1:0] nxt_a,
   output logic          mod_hi,
   output logic          bnd,
   output logic          fp
);
   logic [NW-1:0] main_rem;
   logic [AW-1:0] swal_rem;

   assign mod_hi = (swal_rem != '0);
   assign bnd    = tick && (main_rem == NW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_rem <= NW'(DEF_N);
         swal_rem <= AW'(DEF_A);
         fp       <= 1'b0;
      end else begin
         fp <= bnd;
         if (bnd) begin
            main_rem <= nxt_n;
            swal_rem <= nxt_a;
         end else if (tick) begin
            main_rem <= main_rem - 1'b1;
            if (swal_rem != '0) swal_rem <= swal_rem - 1'b1;
         end
      end
   end

   assert_fp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fp |=> !fp);
   assert_main_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
      main_rem != '0);
   assert_swallow_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (swal_rem != '0) |-> (32'(main_rem) > 32'(swal_rem)));
   assert_mod_fall_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mod_hi) |-> $past(tick));
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
   import psw_pkg::*;
#(
   parameter int NW      = 11,
   parameter int AW      = 7,
   parameter int P_LO    = 32,
   parameter int P_HI    = 64,
   parameter int DEF_N   = 8,
   parameter int DEF_A   = 3,
   parameter bit DEF_SEL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NW-1:0] ratio_n,
   input  logic [AW-1:0] ratio_a,
   input  logic          narrow_sel,
   input  logic          ratio_load,
   output logic          fp_pulse,
   output logic          mod_ctrl,
   output logic          ratio_err
);
   generate
      if (!(DEF_N >= int'(N_MIN) && DEF_A >= 0 && DEF_A < DEF_N && DEF_N < (1 << NW)
            && DEF_A < (1 << AW))) begin : g_bad_default
         $error("pulse_swallow_div: reset-default ratio is illegal");
      end
   endgenerate

   logic          tick, bnd, mod_hi;
   logic [NW-1:0] nxt_n;
   logic [AW-1:0] nxt_a;
   psc_mode_e     act_mode;

   psw_cfg #(.NW(NW), .AW(AW), .DEF_N(DEF_N), .DEF_A(DEF_A), .DEF_SEL(DEF_SEL)) u_cfg (
      .clk(clk), .rst_n(rst_n), .ld(ratio_load), .ld_n(ratio_n), .ld_a(ratio_a),
      .ld_sel(narrow_sel), .bnd(bnd), .nxt_n(nxt_n), .nxt_a(nxt_a),
      .act_mode(act_mode), .err(ratio_err));

   psw_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_psc (
      .clk(clk), .rst_n(rst_n), .mode(act_mode), .mod_hi(mod_hi), .tick(tick));

   psw_counters #(.NW(NW), .AW(AW), .DEF_N(DEF_N), .DEF_A(DEF_A)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .nxt_n(nxt_n), .nxt_a(nxt_a),
      .mod_hi(mod_hi), .bnd(bnd), .fp(fp_pulse));

   assign mod_ctrl = mod_hi;

   assert_fp_after_bnd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bnd |=> fp_pulse);
endmodule

// File: tb/tb_pulse_swallow_div.sv
`timescale 1ns/1ps
module tb_pulse_swallow_div;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] ratio_n = '0;
   logic [6:0]  ratio_a = '0;
   logic        narrow_sel = 1'b0;
   logic        ratio_load = 1'b0;
   logic        fp_pulse, mod_ctrl, ratio_err;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   pulse_swallow_div dut (
      .clk(clk), .rst_n(rst_n), .ratio_n(ratio_n), .ratio_a(ratio_a),
      .narrow_sel(narrow_sel), .ratio_load(ratio_load),
      .fp_pulse(fp_pulse), .mod_ctrl(mod_ctrl), .ratio_err(ratio_err));

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++;
         $display("FAIL watchdog (all requirements) actual=%0d expected<=150000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", total + 1, bad);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_fp();
      do @(negedge clk); while (!fp_pulse);
   endtask

   task automatic do_load(input int n, input int a, input bit sel);
      @(negedge clk);
      ratio_n = 11'(n); ratio_a = 7'(a); narrow_sel = sel; ratio_load = 1'b1;
      @(negedge clk);
      ratio_load = 1'b0;
   endtask

   // Called at a negedge where fp_pulse is high; measures one full period.
   task automatic measure(input string req, input int exp_len, input int exp_hi);
      int cnt = 0;
      int hi = 0;
      int wide = 0;
      do begin
         @(negedge clk);
         cnt++;
         if (cnt == 1 && fp_pulse) wide = 1;
         if (mod_ctrl) hi++;
      end while (!fp_pulse && cnt < 20000);
      check({req, " period"}, cnt, exp_len);
      check({req, " mod_ctrl high cycles R4"}, hi, exp_hi);
      check("R6 fp width one cycle", wide, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 fp_pulse after reset", int'(fp_pulse), 0);
      check("R1 mod_ctrl after reset", int'(mod_ctrl), 1);
      check("R1 ratio_err after reset", int'(ratio_err), 0);
   endtask

   task automatic t_default();
      wait_fp();
      measure("R1 R2 default 32*8+3", 259, 3 * 33);
   endtask

   task automatic t_wide();
      do_load(10, 7, 1'b0);
      wait_fp();
      measure("R3 64*10+7", 647, 7 * 65);
   endtask

   task automatic t_zero_swallow();
      do_load(6, 0, 1'b1);
      wait_fp();
      measure("R5 32*6+0", 192, 0);
   endtask

   task automatic t_min();
      do_load(5, 4, 1'b1);
      check("R11 limit set accepted", int'(ratio_err), 0);
      wait_fp();
      measure("R11 32*5+4", 164, 4 * 33);
   endtask

   task automatic t_bad_n();
      do_load(4, 0, 1'b0);
      check("R8 ratio_err on N<5", int'(ratio_err), 1);
      wait_fp();
      measure("R8 ratio kept", 164, 4 * 33);
   endtask

   task automatic t_bad_a();
      do_load(6, 6, 1'b0);
      check("R9 ratio_err on A==N", int'(ratio_err), 1);
      wait_fp();
      measure("R9 ratio kept", 164, 4 * 33);
   endtask

   task automatic t_clear();
      do_load(7, 2, 1'b0);
      check("R10 ratio_err cleared", int'(ratio_err), 0);
      wait_fp();
      measure("R10 R3 64*7+2", 450, 2 * 65);
   endtask

   task automatic t_midload();
      int cnt = 0;
      wait_fp();
      repeat (9) begin @(negedge clk); cnt++; end
      do_load(9, 1, 1'b1);
      cnt += 2;
      do begin @(negedge clk); cnt++; end while (!fp_pulse && cnt < 20000);
      check("R7 current period keeps old ratio", cnt, 450);
      measure("R7 R2 next period 32*9+1", 289, 33);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_default();
      t_wide();
      t_zero_swallow();
      t_min();
      t_bad_n();
      t_bad_a();
      t_clear();
      t_midload();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule